// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block guards a single shared lock word for several requester ports. A port takes the lock with a retry loop. It reads the word with a load-linked operation and keeps reading while the value is nonzero. Once it reads zero, it attempts a store-conditional that writes 1. The block keeps one reservation flag per port. A store-conditional takes effect only while its port still holds a reservation. Any store that reaches the word cancels the reservations of every other port. When several ports race for a free lock, only the first store-conditional to be granted wins.

Each port raises `req_valid` with an operation code and write data, and holds them until it sees its `gnt` bit at a clock edge. Only one request is served per cycle, so operations are fully serialized. A rotating pointer picks among the ports that are requesting. One cycle after the grant, the port receives a single-cycle `resp_valid` pulse. The pulse carries the lock value seen by the operation and, for a store-conditional, the success flag. A port releases the lock with a plain write of 0, which starts a new race.

Top module: `llsc_monitor`

## Requirements
- R1: After reset the lock word is 0, no port holds a reservation, and `gnt` and `resp_valid` are all zero.
- R2: Operation codes in `req_op` (two bits per port): 2'b00 is load-linked, 2'b01 is store-conditional, 2'b10 and 2'b11 are plain write. A granted load-linked returns the current lock word on `resp_rdata` and sets that port's reservation.
- R3: A granted store-conditional from a port that holds a reservation writes its data to the lock word and returns `resp_ok` = 1.
- R4: A granted store-conditional from a port without a reservation returns `resp_ok` = 0 and leaves the lock word unchanged.
- R5: A port's reservation is cleared by its own granted store-conditional, whether it succeeds or fails.
- R6: A successful store-conditional or a plain write clears the reservations of all other ports. A plain write stores its data unconditionally and returns `resp_ok` = 0.
- R7: At most one `gnt` bit is high in any cycle, and only for a port with `req_valid` high. A request that is not granted stays pending.
- R8: The grant goes to the first requesting port found when searching upward, with wraparound, from the port after the most recent winner. The search starts at port 0 after reset.
- R9: The cycle after a grant, `resp_valid` is high for exactly the granted port, for one cycle. `resp_rdata` then holds the lock word as it was before the operation.
- R10: When several ports that hold reservations issue store-conditionals in the same race, exactly one of them returns `resp_ok` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORT | Per-port request, held until granted |
| req_op | input | 2*NPORT | Per-port operation code, port p in bits [2p+1:2p] |
| req_wdata | input | NPORT*DW | Per-port write data, port p in bits [p*DW +: DW] |
| gnt | output | NPORT | One-hot grant, valid in the cycle it is taken |
| resp_valid | output | NPORT | One-cycle response pulse for the port granted last cycle |
| resp_rdata | output | DW | Lock word before the granted operation |
| resp_ok | output | 1 | Store-conditional success flag |

## Verification
A single port runs an uncontended acquire, spin and release sequence. This separates the read-and-reserve path from the conditional store. A store-conditional with no prior load-linked, and a store-conditional issued after a release by another port, show that the store is refused when the reservation is missing or was cancelled. Three ports then load-link a free lock together and all issue store-conditionals at once. This race must yield a single winner, and the failed stores must leave the lock word unchanged. Last, all ports request in the same cycle, and the order of the grants is compared with the rotation predicted from the previous winner.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int NPORT = 4,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT-1:0]    req_valid,
  input  logic [2*NPORT-1:0]  req_op,
  input  logic [NPORT*DW-1:0] req_wdata,
  output logic [NPORT-1:0]    gnt,
  output logic [NPORT-1:0]    resp_valid,
  output logic [DW-1:0]       resp_rdata,
  output logic                resp_ok
);
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic [DW-1:0]    lock_q;
  logic [NPORT-1:0] rsv_q;
  logic [PW-1:0]    ptr_q;
  logic [PW-1:0]    win;
  logic             any;

  always_comb begin
    int idx;
    win = '0;
    any = 1'b0;
    for (int i = 0; i < NPORT; i++) begin
      idx = (int'(ptr_q) + i) % NPORT;
      if (!any && req_valid[idx]) begin
        any = 1'b1;
        win = PW'(idx);
      end
    end
  end

  logic [1:0]    w_op;
  logic [DW-1:0] w_data;
  logic          is_ll, is_sc, is_wr, sc_ok;

  assign gnt    = any ? (NPORT'(1) << win) : '0;
  assign w_op   = req_op[int'(win)*2 +: 2];
  assign w_data = req_wdata[int'(win)*DW +: DW];
  assign is_ll  = (w_op == 2'b00);
  assign is_sc  = (w_op == 2'b01);
  assign is_wr  = w_op[1];
  assign sc_ok  = is_sc && rsv_q[win];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q     <= '0;
      rsv_q      <= '0;
      ptr_q      <= '0;
      resp_valid <= '0;
      resp_rdata <= '0;
      resp_ok    <= 1'b0;
    end else begin
      resp_valid <= gnt;
      resp_ok    <= any && sc_ok;
      if (any) begin
        resp_rdata <= lock_q;
        ptr_q      <= (win == PW'(NPORT-1)) ? '0 : win + 1'b1;
        if (is_ll) begin
          rsv_q <= rsv_q | gnt;
        end else if (is_wr) begin
          lock_q <= w_data;
          rsv_q  <= rsv_q & gnt;
        end else if (sc_ok) begin
          lock_q <= w_data;
          rsv_q  <= '0;
        end else begin
          rsv_q <= rsv_q & ~gnt;
        end
      end
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int NPORT = 4,
  parameter int DW    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NPORT-1:0]   req_valid,
  input logic [2*NPORT-1:0] req_op,
  input logic [NPORT-1:0]   gnt,
  input logic [NPORT-1:0]   resp_valid,
  input logic               resp_ok,
  input logic [NPORT-1:0]   rsv_q,
  input logic [DW-1:0]      lock_q
);
  logic [NPORT-1:0] sc_g;
  always_comb
    for (int i = 0; i < NPORT; i++)
      sc_g[i] = gnt[i] && (req_op[2*i +: 2] == 2'b01);

  // R7
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  // R7
  gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req_valid) == '0);
  // R9
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) (|gnt) |=> resp_valid == $past(gnt));
  // R5
  own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) (|sc_g) |=> (rsv_q & $past(sc_g)) == '0);
  // R4
  lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(lock_q) |-> $past(|gnt));
  // R10
  ok_single_chk: assert property (@(posedge clk) disable iff (!rst_n) resp_ok |-> $countones(resp_valid) == 1);
  // R6
  win_clears_chk: assert property (@(posedge clk) disable iff (!rst_n) resp_ok |-> rsv_q == '0);
endmodule

bind llsc_monitor llsc_monitor_chk #(.NPORT(NPORT), .DW(DW)) u_chk (.*);

// File: tb/llsc_monitor_test.sv
module llsc_monitor_test;
  localparam int NP = 4;
  localparam int DW = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0]    vld = '0;
  logic [2*NP-1:0]  ops = '0;
  logic [NP*DW-1:0] wds = '0;
  logic [NP-1:0]    gnt, resp_valid;
  logic [DW-1:0]    resp_rdata;
  logic             resp_ok;

  always #(CLK_PERIOD/2) clk = ~clk;

  llsc_monitor #(.NPORT(NP), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(vld), .req_op(ops), .req_wdata(wds),
    .gnt(gnt), .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_ok(resp_ok));

  typedef struct {int port; logic ok; logic ll; logic [DW-1:0] data; string tag;} exp_t;
  exp_t exq[$];
  int glog[$];
  int errors = 0, checks = 0, wins = 0, last_win = NP-1;
  logic [DW-1:0] m_lock = '0;
  logic [NP-1:0] m_rsv = '0;
  bit done = 0;

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic port_op(input int p, input logic [1:0] op, input logic [DW-1:0] wd, input string tag);
    exp_t e;
    @(negedge clk);
    vld[p] = 1'b1; ops[2*p +: 2] = op; wds[p*DW +: DW] = wd;
    forever begin
      #1;
      if (gnt[p]) break;
      @(negedge clk);
    end
    e.port = p; e.tag = tag; e.ll = (op == 2'b00); e.data = m_lock; e.ok = 1'b0;
    if (op == 2'b00) m_rsv[p] = 1'b1;
    else if (op[1]) begin m_lock = wd; m_rsv = m_rsv & (NP'(1) << p); end
    else if (m_rsv[p]) begin e.ok = 1'b1; m_lock = wd; m_rsv = '0; end
    else m_rsv[p] = 1'b0;
    exq.push_back(e);
    glog.push_back(p);
    last_win = p;
    @(negedge clk);
    vld[p] = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && resp_valid != '0) begin
      if (exq.size() == 0) chk(0, "R9 unexpected response", int'(resp_valid), 0);
      else begin
        exp_t e;
        e = exq.pop_front();
        chk(resp_valid == (NP'(1) << e.port), {e.tag, " R9 port"}, int'(resp_valid), 1 << e.port);
        chk(resp_ok == e.ok, {e.tag, " ok"}, int'(resp_ok), int'(e.ok));
        if (e.ll) chk(resp_rdata == e.data, {e.tag, " data"}, int'(resp_rdata), int'(e.data));
        if (resp_ok) wins++;
      end
    end
  end

  task automatic drain;
    repeat (3) @(negedge clk);
    chk(resp_valid == '0 && exq.size() == 0, "R9 pulse ended", int'(resp_valid), 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(gnt == '0 && resp_valid == '0, "R1 reset outputs", int'(resp_valid), 0);
    rst_n = 1'b1;
    port_op(0, 2'b00, 0, "R1 initial lock zero");
    port_op(0, 2'b01, 1, "R3 sc with reservation");
    port_op(1, 2'b00, 0, "R2 ll spins on locked");
    port_op(2, 2'b01, 5, "R4 sc without reservation");
    port_op(3, 2'b00, 0, "R4 lock unchanged");
    port_op(0, 2'b10, 0, "R6 release write");
    port_op(1, 2'b01, 1, "R6 reservation cancelled");
    port_op(2, 2'b00, 0, "R4 lock still free");
    drain();
    fork
      port_op(1, 2'b00, 0, "R2 race ll p1");
      port_op(2, 2'b00, 0, "R2 race ll p2");
      port_op(3, 2'b00, 0, "R2 race ll p3");
    join
    wins = 0;
    fork
      port_op(1, 2'b01, 1, "R10 race sc p1");
      port_op(2, 2'b01, 1, "R10 race sc p2");
      port_op(3, 2'b01, 1, "R10 race sc p3");
    join
    drain();
    chk(wins == 1, "R10 single winner", wins, 1);
    port_op(2, 2'b11, 0, "R6 release via op 3");
    port_op(1, 2'b00, 0, "R2 ll after release");
    port_op(1, 2'b01, 7, "R3 sc stores data");
    port_op(1, 2'b01, 9, "R5 second sc fails");
    port_op(0, 2'b00, 0, "R5 lock kept first sc data");
    drain();
    begin
      int start, lw;
      lw = last_win;
      glog.delete();
      fork
        port_op(0, 2'b00, 0, "R8 all request p0");
        port_op(1, 2'b00, 0, "R8 all request p1");
        port_op(2, 2'b00, 0, "R8 all request p2");
        port_op(3, 2'b00, 0, "R8 all request p3");
      join
      start = (lw + 1) % NP;
      for (int k = 0; k < NP; k++)
        chk(glog[k] == (start + k) % NP, "R8 R7 grant order", glog[k], (start + k) % NP);
    end
    drain();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end
endmodule